// File: doc/BRIEF.md
# PLL Lock and Acquisition Supervisor

This block watches over a phase-locked loop from the register side. The analog loop is modelled as an unsigned frequency-error magnitude that arrives on `errMag` every clock. From it the block keeps two status flags. The filter-mode flag (`acq`) is 0 for acquisition and 1 for tracking. The lock flag is `lock`. Each flag has its own pair of thresholds: an entry threshold and a wider exit threshold. This hysteresis stops a noisy error from toggling the flags.

Software drives the block through an 8-bit write port and reads it back through an 8-bit read word. In automatic mode the hardware drives both flags, and a change of lock can raise a held interrupt request. In manual mode, software writes the filter-mode bit, and lock reporting and interrupts are suppressed. Two sticky error bits report misuse. One is set when the PLL is started in manual mode with tracking requested. The other is set when the loop clock is selected while lock is absent in automatic mode.

Top module: `pll_lock_supervisor`

## Requirements
- R1: While the PLL is on and in automatic mode, read bit 2 (`acq`) becomes 1 one cycle after `errMag <= trackThr` is seen. It becomes 0 one cycle after `errMag > untrackThr` is seen. For any other error it keeps its value.
- R2: While the PLL is on and in automatic mode, read bit 5 (`lock`) becomes 1 one cycle after `errMag <= lockThr` is seen. It becomes 0 one cycle after `errMag > unlockThr` is seen. For any other error it keeps its value.
- R3: In automatic mode with the PLL on and write bit 3 (interrupt enable) set, any change of `lock` in either direction sets `irqReq` at the same edge. `irqReq` then stays high until a write with bit 5 (acknowledge) set. A new lock change in the same cycle as an acknowledge wins.
- R4: In manual mode with the PLL on, a write loads bit 2 into `acq`. In automatic mode, the written bit 2 is ignored.
- R5: In manual mode (bit 1 = 0), `lock` reads 0 and `irqReq` is 0 from the next cycle on.
- R6: In manual mode with the PLL off, a write that sets bit 0 (PLL on) together with bit 2 sets the sticky read bit 6. In that case `acq` stays 0.
- R7: When automatic mode and clock select (bit 4) are both set while `lock` is 0, sticky read bit 7 is set at the next edge. Only reset clears it.
- R8: While bit 0 (PLL on) is 0, `acq`, `lock` and `irqReq` are 0 from the next cycle on.
- R9: Synchronous active-high reset clears every bit. This leaves manual mode with the PLL off, a read word of 0 and `irqReq` low.
- R10: Write bits 0, 1, 3 and 4 are stored and read back at the same positions. Write bit 5 is acknowledge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| errMag | input | ERR_W | Frequency error magnitude |
| trackThr | input | ERR_W | Entry threshold of tracking |
| untrackThr | input | ERR_W | Exit threshold of tracking |
| lockThr | input | ERR_W | Entry threshold of lock |
| unlockThr | input | ERR_W | Exit threshold of lock |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write word: 0 on, 1 auto, 2 acq, 3 irq enable, 4 clock select, 5 acknowledge |
| rdData | output | 8 | Read word: 0 on, 1 auto, 2 acq, 3 irq enable, 4 clock select, 5 lock, 6 sequencing error, 7 noise |
| irqReq | output | 1 | Held lock-change interrupt request |

## Verification
The bench builds the block with `ERR_W = 8` and thresholds of 10/20 for tracking and 5/8 for lock. Small error values can then land exactly on each entry threshold and each exit threshold, inside each hold band, and just beyond each exit threshold. The default width is 12 bits. The run takes the block through automatic locking and unlocking with acknowledges, and then the noise condition. It then switches to manual mode, where lock is suppressed even at zero error. Last come the power-off paths, including a sequencing error and the clearing of a pending interrupt.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;
  localparam int REG_W = 8;
  localparam int B_ON = 0;
  localparam int B_AUTO = 1;
  localparam int B_ACQ = 2;
  localparam int B_IEN = 3;
  localparam int B_CSEL = 4;
  localparam int B_ACK = 5;
  localparam int B_LOCK = 5;
  localparam int B_SEQ = 6;
  localparam int B_NOISE = 7;

  typedef struct packed {
    logic clear;
    logic hwRun;
    logic acqLoad;
    logic acqVal;
  } dpStrobe_t;
endpackage

// File: rtl/pll_sup_dp.sv
module pll_sup_dp
  import pll_sup_pkg::*;
#(
  parameter int ERR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [ERR_W-1:0] errMag,
  input  logic [ERR_W-1:0] trackThr,
  input  logic [ERR_W-1:0] untrackThr,
  input  logic [ERR_W-1:0] lockThr,
  input  logic [ERR_W-1:0] unlockThr,
  output logic             acq,
  output logic             lock,
  output logic             lockChange
);
  localparam int N_WIN = 2;
  localparam int W_ACQ = 0;
  localparam int W_LOCK = 1;

  logic [ERR_W-1:0] enterThr [N_WIN];
  logic [ERR_W-1:0] exitThr  [N_WIN];
  logic [N_WIN-1:0] flagQ;
  logic [N_WIN-1:0] flagNext;

  assign enterThr[W_ACQ]  = trackThr;
  assign exitThr[W_ACQ]   = untrackThr;
  assign enterThr[W_LOCK] = lockThr;
  assign exitThr[W_LOCK]  = unlockThr;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    always_comb begin
      if (errMag <= enterThr[w])     flagNext[w] = 1'b1;
      else if (errMag > exitThr[w])  flagNext[w] = 1'b0;
      else                           flagNext[w] = flagQ[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= '0;
    end else if (strb.clear) begin
      flagQ <= '0;
    end else if (strb.hwRun) begin
      flagQ <= flagNext;
    end else begin
      flagQ[W_LOCK] <= 1'b0;
      if (strb.acqLoad) flagQ[W_ACQ] <= strb.acqVal;
    end
  end

  assign acq        = flagQ[W_ACQ];
  assign lock       = flagQ[W_LOCK];
  assign lockChange = strb.hwRun && (flagNext[W_LOCK] != flagQ[W_LOCK]);
endmodule

// File: rtl/pll_sup_ctrl.sv
module pll_sup_ctrl
  import pll_sup_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             acq,
  input  logic             lock,
  input  logic             lockChange,
  output dpStrobe_t        strb,
  output logic [REG_W-1:0] rdData,
  output logic             irqReq
);
  logic pllOn, autoMode, irqEn, clkSel;
  logic irqPend, seqErr, noiseErr;

  always_comb begin
    strb.clear   = !pllOn;
    strb.hwRun   = pllOn && autoMode;
    strb.acqLoad = wrEn && pllOn && !autoMode;
    strb.acqVal  = wrData[B_ACQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pllOn    <= 1'b0;
      autoMode <= 1'b0;
      irqEn    <= 1'b0;
      clkSel   <= 1'b0;
    end else if (wrEn) begin
      pllOn    <= wrData[B_ON];
      autoMode <= wrData[B_AUTO];
      irqEn    <= wrData[B_IEN];
      clkSel   <= wrData[B_CSEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqPend <= 1'b0;
    end else if (!(pllOn && autoMode)) begin
      irqPend <= 1'b0;
    end else if (lockChange && irqEn) begin
      irqPend <= 1'b1;
    end else if (wrEn && wrData[B_ACK]) begin
      irqPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seqErr   <= 1'b0;
      noiseErr <= 1'b0;
    end else begin
      if (wrEn && !autoMode && !pllOn && wrData[B_ON] && wrData[B_ACQ])
        seqErr <= 1'b1;
      if (autoMode && clkSel && !lock)
        noiseErr <= 1'b1;
    end
  end

  always_comb begin
    rdData          = '0;
    rdData[B_ON]    = pllOn;
    rdData[B_AUTO]  = autoMode;
    rdData[B_ACQ]   = acq;
    rdData[B_IEN]   = irqEn;
    rdData[B_CSEL]  = clkSel;
    rdData[B_LOCK]  = lock;
    rdData[B_SEQ]   = seqErr;
    rdData[B_NOISE] = noiseErr;
  end

  assign irqReq = irqPend;
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
  import pll_sup_pkg::*;
#(
  parameter int ERR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] errMag,
  input  logic [ERR_W-1:0] trackThr,
  input  logic [ERR_W-1:0] untrackThr,
  input  logic [ERR_W-1:0] lockThr,
  input  logic [ERR_W-1:0] unlockThr,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             irqReq
);
  dpStrobe_t strb;
  logic acq, lock, lockChange;

  pll_sup_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .acq(acq), .lock(lock), .lockChange(lockChange),
    .strb(strb), .rdData(rdData), .irqReq(irqReq)
  );

  pll_sup_dp #(.ERR_W(ERR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .errMag(errMag),
    .trackThr(trackThr), .untrackThr(untrackThr),
    .lockThr(lockThr), .unlockThr(unlockThr),
    .acq(acq), .lock(lock), .lockChange(lockChange)
  );
endmodule

// File: rtl/pll_sup_checker.sv
module pll_sup_checker #(
  parameter int ERR_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [ERR_W-1:0] errMag,
  input logic [ERR_W-1:0] trackThr,
  input logic [ERR_W-1:0] untrackThr,
  input logic [ERR_W-1:0] lockThr,
  input logic [ERR_W-1:0] unlockThr,
  input logic [7:0]       rdData,
  input logic             irqReq
);
  logic runHw;
  assign runHw = rdData[0] && rdData[1];

  p_acq_enter_r1: assert property (@(posedge clk) disable iff (rst)
    (runHw && errMag <= trackThr) |=> rdData[2]);
  p_acq_exit_r1: assert property (@(posedge clk) disable iff (rst)
    (runHw && errMag > untrackThr) |=> !rdData[2]);
  p_lock_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (runHw && errMag <= lockThr) |=> rdData[5]);
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (runHw && rdData[5] && errMag <= unlockThr) |=> rdData[5]);
  p_lock_manual_r5: assert property (@(posedge clk) disable iff (rst)
    !rdData[1] |=> !rdData[5]);
  p_irq_manual_r5: assert property (@(posedge clk) disable iff (rst)
    !rdData[1] |=> !irqReq);
  p_seq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    rdData[6] |=> rdData[6]);
  p_noise_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    rdData[7] |=> rdData[7]);
  p_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !rdData[0] |=> (!rdData[2] && !rdData[5] && !irqReq));
endmodule

bind pll_lock_supervisor pll_sup_checker #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .errMag(errMag), .trackThr(trackThr),
  .untrackThr(untrackThr), .lockThr(lockThr), .unlockThr(unlockThr),
  .rdData(rdData), .irqReq(irqReq)
);

// File: tb/sim_pll_lock_supervisor.sv
module sim_pll_lock_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 8;

  typedef struct {
    string      req;
    logic [7:0] rd;
    logic       irq;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [EW-1:0] errMag = '0;
  logic [EW-1:0] trackThr = 8'd10, untrackThr = 8'd20;
  logic [EW-1:0] lockThr = 8'd5, unlockThr = 8'd8;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqReq;

  int nCompared = 0;
  int nMismatch = 0;
  expItem_t expQ[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_supervisor #(.ERR_W(EW)) u0 (
    .clk(clk), .rst(rst), .errMag(errMag), .trackThr(trackThr),
    .untrackThr(untrackThr), .lockThr(lockThr), .unlockThr(unlockThr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqReq(irqReq)
  );

  initial begin : monitor
    expItem_t it;
    forever begin
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      nCompared++;
      if (rdData !== it.rd || irqReq !== it.irq) begin
        nMismatch++;
        $display("FAIL %s: rd=%02h irq=%0b expected rd=%02h irq=%0b",
                 it.req, rdData, irqReq, it.rd, it.irq);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_now(input string req, input logic [7:0] rd, input logic irq);
    expItem_t it;
    it.req = req; it.rd = rd; it.irq = irq;
    expQ.push_back(it);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    cyc();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic step(input logic [EW-1:0] e);
    errMag = e;
    cyc();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nCompared++; nMismatch++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin : driver
    @(negedge clk);
    repeat (3) cyc();
    rst = 1'b0;
    expect_now("R9 reset", 8'h00, 1'b0);

    errMag = 8'd50;
    wr(8'h0B);                 expect_now("R10 write readback", 8'h0B, 1'b0);
    step(8'd50);               expect_now("R1 far error", 8'h0B, 1'b0);
    step(8'd10);               expect_now("R1 enter at threshold", 8'h0F, 1'b0);
    step(8'd20);               expect_now("R1 hold at exit threshold", 8'h0F, 1'b0);
    step(8'd21);               expect_now("R1 exit beyond threshold", 8'h0B, 1'b0);
    step(8'd5);                expect_now("R2 R3 lock at threshold irq", 8'h2F, 1'b1);
    errMag = 8'd8; wr(8'h2B);  expect_now("R3 ack R2 hold at 8", 8'h2F, 1'b0);
    step(8'd9);                expect_now("R2 R3 unlock irq", 8'h0F, 1'b1);
    errMag = 8'd9; wr(8'h3B);  expect_now("R10 clock select, R3 ack", 8'h1F, 1'b0);
    step(8'd15);               expect_now("R7 noise sticky set", 8'h9F, 1'b0);
    errMag = 8'd15; wr(8'h1B); expect_now("R4 auto acq write ignored", 8'h9F, 1'b0);

    errMag = 8'd15; wr(8'h01); expect_now("R10 to manual", 8'h85, 1'b0);
    step(8'd0);                expect_now("R5 manual lock suppressed", 8'h85, 1'b0);
    wr(8'h01);                 expect_now("R4 manual acq clear", 8'h81, 1'b0);
    wr(8'h05);                 expect_now("R4 manual acq set", 8'h85, 1'b0);
    wr(8'h00);                 expect_now("R8 power off", 8'h80, 1'b0);
    wr(8'h05);                 expect_now("R6 sequencing error", 8'hC1, 1'b0);

    wr(8'h0A);                 expect_now("R8 off auto", 8'hCA, 1'b0);
    step(8'd0);                expect_now("R8 off forces flags", 8'hCA, 1'b0);
    errMag = 8'd0; wr(8'h0B);  expect_now("R8 power on", 8'hCB, 1'b0);
    step(8'd0);                expect_now("R2 R3 relock irq", 8'hEF, 1'b1);
    errMag = 8'd0; wr(8'h0A);  expect_now("R3 irq held until off", 8'hEE, 1'b1);
    step(8'd0);                expect_now("R8 off clears irq", 8'hCA, 1'b0);

    wait (expQ.size() == 0);
    #1;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule